// File: doc/BRIEF.md
# Single-Cycle Main Control Decoder

This block is the combinational main control of a single-cycle processor that runs a small integer subset of a classic 32-bit load/store instruction set. From the 6-bit major opcode and the 6-bit function field of the current instruction, it drives every datapath steering wire in the same cycle. These wires are:

- destination-register select
- second ALU operand select
- write-back source select
- register write enable
- memory read and write strobes
- branch-on-equal and jump selects
- the ALU operation, together with its invert-second-operand bit

No second ALU-control stage sits behind the decoder. The ALU operation comes straight from the opcode and function field.

Every recognised instruction raises `known_o`. An opcode outside the supported set, or an R-format opcode whose function code is outside the set, drops `known_o` and holds all controls low. Any control that cannot influence the current cycle is driven to zero. A wide bank of spare control lines is kept for later extensions and stays at zero for the whole supported set.

Top module: `scd_main_ctrl`

## Requirements
- R1: With opcode 0x00 (R-format), the decoder sets dst_rd_o=1, reg_we_o=1, alu_src_imm_o=0, and no memory, branch or jump control. The ALU fields follow the function code: 0x20 and 0x21 give op 2 with neg 0; 0x22 and 0x23 give op 2 with neg 1; 0x24 gives op 0; 0x25 gives op 1; 0x26 gives op 4; 0x2A gives op 3 with neg 1.
- R2: Opcodes 0x08 and 0x09 (add immediate, signed and unsigned forms alike) give alu_src_imm_o=1, reg_we_o=1, ALU op 2 with neg 0, and all other controls 0.
- R3: Opcode 0x0A (set-less-than immediate) gives alu_src_imm_o=1, reg_we_o=1, ALU op 3 with neg 1, and all other controls 0.
- R4: Opcode 0x23 (load word) gives alu_src_imm_o=1, mem_rd_o=1, wb_mem_o=1, reg_we_o=1, ALU op 2 with neg 0, and all other controls 0.
- R5: Opcode 0x2B (store word) gives alu_src_imm_o=1, mem_wr_o=1, ALU op 2 with neg 0, and all other controls 0, including dst_rd_o and wb_mem_o.
- R6: Opcode 0x04 (branch if equal) gives br_eq_o=1, ALU op 2 with neg 1, and all other controls 0.
- R7: Opcode 0x02 (jump) gives jmp_o=1, with ALU op 0, neg 0 and every other control 0.
- R8: Any other opcode, or opcode 0x00 with a function code not listed in R1, gives known_o=0 with every control output 0. Every supported instruction gives known_o=1.
- R9: spare_o is all zeros for every input.
- R10: For every opcode other than 0x00, the function field has no effect on any output.
- R11: Whenever reg_we_o is 0, both dst_rd_o and wb_mem_o are 0. mem_rd_o and mem_wr_o are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode_i | input | OPCODE_W (6) | Major opcode of the current instruction |
| funct_i | input | FUNCT_W (6) | Function field, used only for R-format |
| dst_rd_o | output | 1 | Write destination comes from the rd field (else rt) |
| alu_src_imm_o | output | 1 | ALU second operand is the sign-extended immediate |
| wb_mem_o | output | 1 | Register write-back data comes from memory |
| reg_we_o | output | 1 | Register file write enable |
| mem_rd_o | output | 1 | Data memory read strobe |
| mem_wr_o | output | 1 | Data memory write strobe |
| br_eq_o | output | 1 | Take branch when the ALU reports zero |
| jmp_o | output | 1 | Next PC comes from the jump target |
| alu_op_o | output | ALU_OP_W (3) | ALU operation: 0 AND, 1 OR, 2 add/sub, 3 less-than, 4 XOR |
| alu_neg_o | output | 1 | Invert the ALU's second operand and carry in one |
| spare_o | output | SPARE_W (96) | Reserved extension control lines |
| known_o | output | 1 | Instruction is in the supported set |

## Verification
The bench builds the block with its default widths: 6-bit opcode and function fields, a 3-bit ALU operation and 96 spare lines. With both 6-bit fields at default width, the input space is only 4096 pairs. Every pair is driven once, one pair per clock, and the bench compares each against a behavioural model. This covers every invalid opcode and every unused R-format function code, and it shows that the function field is ignored for all 63 non-R-format opcodes. Directed checks then name each supported instruction and the boundary codes next to the valid ones.

// File: rtl/scd_pkg.sv
package scd_pkg;

   localparam int OP_BITS = 6;
   localparam int FN_BITS = 6;

   localparam logic [OP_BITS-1:0] OPC_RFMT  = 6'h00;
   localparam logic [OP_BITS-1:0] OPC_JUMP  = 6'h02;
   localparam logic [OP_BITS-1:0] OPC_BREQ  = 6'h04;
   localparam logic [OP_BITS-1:0] OPC_ADDI  = 6'h08;
   localparam logic [OP_BITS-1:0] OPC_ADDIU = 6'h09;
   localparam logic [OP_BITS-1:0] OPC_SLTI  = 6'h0A;
   localparam logic [OP_BITS-1:0] OPC_LOAD  = 6'h23;
   localparam logic [OP_BITS-1:0] OPC_STORE = 6'h2B;

   localparam logic [FN_BITS-1:0] FN_ADD  = 6'h20;
   localparam logic [FN_BITS-1:0] FN_ADDU = 6'h21;
   localparam logic [FN_BITS-1:0] FN_SUB  = 6'h22;
   localparam logic [FN_BITS-1:0] FN_SUBU = 6'h23;
   localparam logic [FN_BITS-1:0] FN_AND  = 6'h24;
   localparam logic [FN_BITS-1:0] FN_OR   = 6'h25;
   localparam logic [FN_BITS-1:0] FN_XOR  = 6'h26;
   localparam logic [FN_BITS-1:0] FN_SLT  = 6'h2A;

   typedef enum logic [2:0] {
      ALU_AND = 3'd0,
      ALU_OR  = 3'd1,
      ALU_ADD = 3'd2,
      ALU_LT  = 3'd3,
      ALU_XOR = 3'd4
   } alu_op_e;

   typedef enum logic [2:0] {
      CLS_NONE,
      CLS_RFMT,
      CLS_ARITH_IMM,
      CLS_LT_IMM,
      CLS_LOAD,
      CLS_STORE,
      CLS_BREQ,
      CLS_JUMP
   } op_class_e;

   typedef struct packed {
      logic    dst_rd;
      logic    src_imm;
      logic    wb_mem;
      logic    reg_we;
      logic    mem_rd;
      logic    mem_wr;
      logic    br_eq;
      logic    jmp;
      alu_op_e alu_op;
      logic    alu_neg;
   } ctrl_t;

   localparam ctrl_t CTRL_IDLE = '{
      dst_rd: 1'b0, src_imm: 1'b0, wb_mem: 1'b0, reg_we: 1'b0,
      mem_rd: 1'b0, mem_wr: 1'b0, br_eq: 1'b0, jmp: 1'b0,
      alu_op: ALU_AND, alu_neg: 1'b0};

endpackage

// File: rtl/scd_op_class.sv
module scd_op_class
   import scd_pkg::*;
#(
   parameter int OPCODE_W = 6
) (
   input  logic [OPCODE_W-1:0] opcode_i,
   output op_class_e           cls_o
);

   always_comb begin
      unique case (opcode_i)
         OPC_RFMT:             cls_o = CLS_RFMT;
         OPC_ADDI, OPC_ADDIU:  cls_o = CLS_ARITH_IMM;
         OPC_SLTI:             cls_o = CLS_LT_IMM;
         OPC_LOAD:             cls_o = CLS_LOAD;
         OPC_STORE:            cls_o = CLS_STORE;
         OPC_BREQ:             cls_o = CLS_BREQ;
         OPC_JUMP:             cls_o = CLS_JUMP;
         default:              cls_o = CLS_NONE;
      endcase
   end

endmodule

// File: rtl/scd_funct_dec.sv
module scd_funct_dec
   import scd_pkg::*;
#(
   parameter int FUNCT_W = 6
) (
   input  logic [FUNCT_W-1:0] funct_i,
   output logic               hit_o,
   output alu_op_e            alu_op_o,
   output logic               alu_neg_o
);

   always_comb begin
      hit_o     = 1'b1;
      alu_op_o  = ALU_AND;
      alu_neg_o = 1'b0;
      unique case (funct_i)
         FN_ADD, FN_ADDU: alu_op_o = ALU_ADD;
         FN_SUB, FN_SUBU: begin
            alu_op_o  = ALU_ADD;
            alu_neg_o = 1'b1;
         end
         FN_AND:          alu_op_o = ALU_AND;
         FN_OR:           alu_op_o = ALU_OR;
         FN_XOR:          alu_op_o = ALU_XOR;
         FN_SLT: begin
            alu_op_o  = ALU_LT;
            alu_neg_o = 1'b1;
         end
         default:         hit_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/scd_ctrl_gen.sv
module scd_ctrl_gen
   import scd_pkg::*;
(
   input  op_class_e cls_i,
   input  logic      fn_hit_i,
   input  alu_op_e   fn_alu_op_i,
   input  logic      fn_alu_neg_i,
   output ctrl_t     ctrl_o,
   output logic      known_o
);

   always_comb begin
      ctrl_o  = CTRL_IDLE;
      known_o = 1'b1;
      unique case (cls_i)
         CLS_RFMT: begin
            if (fn_hit_i) begin
               ctrl_o.dst_rd  = 1'b1;
               ctrl_o.reg_we  = 1'b1;
               ctrl_o.alu_op  = fn_alu_op_i;
               ctrl_o.alu_neg = fn_alu_neg_i;
            end else begin
               known_o = 1'b0;
            end
         end
         CLS_ARITH_IMM: begin
            ctrl_o.src_imm = 1'b1;
            ctrl_o.reg_we  = 1'b1;
            ctrl_o.alu_op  = ALU_ADD;
         end
         CLS_LT_IMM: begin
            ctrl_o.src_imm = 1'b1;
            ctrl_o.reg_we  = 1'b1;
            ctrl_o.alu_op  = ALU_LT;
            ctrl_o.alu_neg = 1'b1;
         end
         CLS_LOAD: begin
            ctrl_o.src_imm = 1'b1;
            ctrl_o.mem_rd  = 1'b1;
            ctrl_o.wb_mem  = 1'b1;
            ctrl_o.reg_we  = 1'b1;
            ctrl_o.alu_op  = ALU_ADD;
         end
         CLS_STORE: begin
            ctrl_o.src_imm = 1'b1;
            ctrl_o.mem_wr  = 1'b1;
            ctrl_o.alu_op  = ALU_ADD;
         end
         CLS_BREQ: begin
            ctrl_o.br_eq   = 1'b1;
            ctrl_o.alu_op  = ALU_ADD;
            ctrl_o.alu_neg = 1'b1;
         end
         CLS_JUMP: ctrl_o.jmp = 1'b1;
         default:  known_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/scd_main_ctrl.sv
module scd_main_ctrl
   import scd_pkg::*;
#(
   parameter int OPCODE_W = 6,
   parameter int FUNCT_W  = 6,
   parameter int ALU_OP_W = 3,
   parameter int SPARE_W  = 96,
   parameter int SPARE_WORD_W = 32
) (
   input  logic [OPCODE_W-1:0] opcode_i,
   input  logic [FUNCT_W-1:0]  funct_i,
   output logic                dst_rd_o,
   output logic                alu_src_imm_o,
   output logic                wb_mem_o,
   output logic                reg_we_o,
   output logic                mem_rd_o,
   output logic                mem_wr_o,
   output logic                br_eq_o,
   output logic                jmp_o,
   output logic [ALU_OP_W-1:0] alu_op_o,
   output logic                alu_neg_o,
   output logic [SPARE_W-1:0]  spare_o,
   output logic                known_o
);

   localparam int ENC_W       = $bits(alu_op_e);
   localparam int SPARE_WORDS = (SPARE_W + SPARE_WORD_W - 1) / SPARE_WORD_W;
   localparam int SPARE_PAD_W = SPARE_WORDS * SPARE_WORD_W;

   generate
      if (OPCODE_W != OP_BITS) begin : g_bad_opcode_w
         $error("scd_main_ctrl: OPCODE_W must equal the encoded opcode width");
      end
      if (FUNCT_W != FN_BITS) begin : g_bad_funct_w
         $error("scd_main_ctrl: FUNCT_W must equal the encoded function width");
      end
      if (ALU_OP_W < ENC_W) begin : g_bad_alu_w
         $error("scd_main_ctrl: ALU_OP_W too narrow for the operation set");
      end
      if (SPARE_W < 1 || SPARE_WORD_W < 1) begin : g_bad_spare_w
         $error("scd_main_ctrl: spare widths must be positive");
      end
   endgenerate

   op_class_e cls;
   logic      fn_hit;
   alu_op_e   fn_alu_op;
   logic      fn_alu_neg;
   ctrl_t     ctrl;

   scd_op_class #(.OPCODE_W(OPCODE_W)) u_class (
      .opcode_i (opcode_i),
      .cls_o    (cls)
   );

   scd_funct_dec #(.FUNCT_W(FUNCT_W)) u_funct (
      .funct_i   (funct_i),
      .hit_o     (fn_hit),
      .alu_op_o  (fn_alu_op),
      .alu_neg_o (fn_alu_neg)
   );

   scd_ctrl_gen u_gen (
      .cls_i        (cls),
      .fn_hit_i     (fn_hit),
      .fn_alu_op_i  (fn_alu_op),
      .fn_alu_neg_i (fn_alu_neg),
      .ctrl_o       (ctrl),
      .known_o      (known_o)
   );

   assign dst_rd_o      = ctrl.dst_rd;
   assign alu_src_imm_o = ctrl.src_imm;
   assign wb_mem_o      = ctrl.wb_mem;
   assign reg_we_o      = ctrl.reg_we;
   assign mem_rd_o      = ctrl.mem_rd;
   assign mem_wr_o      = ctrl.mem_wr;
   assign br_eq_o       = ctrl.br_eq;
   assign jmp_o         = ctrl.jmp;
   assign alu_neg_o     = ctrl.alu_neg;

   generate
      if (ALU_OP_W > ENC_W) begin : g_alu_wide
         assign alu_op_o = {{(ALU_OP_W-ENC_W){1'b0}}, ctrl.alu_op};
      end else begin : g_alu_exact
         assign alu_op_o = ctrl.alu_op;
      end
   endgenerate

   logic [SPARE_PAD_W-1:0] spare_pad;

   generate
      for (genvar w = 0; w < SPARE_WORDS; w++) begin : g_spare_word
         assign spare_pad[w*SPARE_WORD_W +: SPARE_WORD_W] = '0;
      end
   endgenerate

   assign spare_o = spare_pad[SPARE_W-1:0];

endmodule

// File: rtl/scd_main_ctrl_chk.sv
module scd_main_ctrl_chk #(
   parameter int OPCODE_W = 6,
   parameter int FUNCT_W  = 6,
   parameter int ALU_OP_W = 3,
   parameter int SPARE_W  = 96
) (
   input logic [OPCODE_W-1:0] opcode_i,
   input logic [FUNCT_W-1:0]  funct_i,
   input logic                dst_rd_o,
   input logic                alu_src_imm_o,
   input logic                wb_mem_o,
   input logic                reg_we_o,
   input logic                mem_rd_o,
   input logic                mem_wr_o,
   input logic                br_eq_o,
   input logic                jmp_o,
   input logic [ALU_OP_W-1:0] alu_op_o,
   input logic                alu_neg_o,
   input logic [SPARE_W-1:0]  spare_o,
   input logic                known_o
);

   logic [7:0] flags;
   assign flags = {dst_rd_o, alu_src_imm_o, wb_mem_o, reg_we_o,
                   mem_rd_o, mem_wr_o, br_eq_o, jmp_o};

   always_comb begin
      p_spare_quiet_r9: assert (spare_o == '0)
         else $error("spare lines active");
      p_dontcare_zero_r11: assert (reg_we_o || (!dst_rd_o && !wb_mem_o))
         else $error("write-back steering set without register write");
      p_mem_exclusive_r11: assert (!(mem_rd_o && mem_wr_o))
         else $error("memory read and write together");
      p_unknown_quiet_r8: assert (known_o || (flags == '0 && alu_op_o == '0 && !alu_neg_o))
         else $error("controls active for unknown instruction");
      p_jump_alone_r7: assert (!jmp_o || ($countones(flags) == 1 && alu_op_o == '0 && !alu_neg_o))
         else $error("jump with other controls");
      p_branch_sub_r6: assert (!br_eq_o || (alu_op_o == 2 && alu_neg_o && !reg_we_o))
         else $error("branch without subtract");
      p_rd_only_rfmt_r1: assert (!dst_rd_o || opcode_i == '0)
         else $error("rd destination outside R-format");
      p_imm_arith_r2: assert (!(opcode_i == 8 || opcode_i == 9) ||
                              (alu_src_imm_o && reg_we_o && alu_op_o == 2 && !alu_neg_o))
         else $error("add immediate mis-decoded");
      p_load_path_r4: assert (mem_rd_o == (opcode_i == 6'h23))
         else $error("load strobe mismatch");
      p_store_path_r5: assert (mem_wr_o == (opcode_i == 6'h2B))
         else $error("store strobe mismatch");
   end

   logic unused_fn;
   assign unused_fn = ^funct_i;

endmodule

bind scd_main_ctrl scd_main_ctrl_chk #(
   .OPCODE_W (OPCODE_W),
   .FUNCT_W  (FUNCT_W),
   .ALU_OP_W (ALU_OP_W),
   .SPARE_W  (SPARE_W)
) u_chk (.*);

// File: tb/scd_main_ctrl_tb.sv
`timescale 1ns/1ps
module scd_main_ctrl_tb_top;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [5:0]  opcode;
   logic [5:0]  funct;
   logic        dst_rd, src_imm, wb_mem, reg_we, mem_rd, mem_wr, br_eq, jmp;
   logic [2:0]  alu_op;
   logic        alu_neg;
   logic [95:0] spare;
   logic        known;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done   = 0;

   scd_main_ctrl dut_i (
      .opcode_i      (opcode),
      .funct_i       (funct),
      .dst_rd_o      (dst_rd),
      .alu_src_imm_o (src_imm),
      .wb_mem_o      (wb_mem),
      .reg_we_o      (reg_we),
      .mem_rd_o      (mem_rd),
      .mem_wr_o      (mem_wr),
      .br_eq_o       (br_eq),
      .jmp_o         (jmp),
      .alu_op_o      (alu_op),
      .alu_neg_o     (alu_neg),
      .spare_o       (spare),
      .known_o       (known)
   );

   // Packed view: {known, dst, imm, wbm, we, rd, wr, br, jmp, op[2:0], neg}
   function automatic logic [12:0] model(input int op, input int fn);
      logic k, d, i, m, w, r, s, b, j, n;
      int   a;
      {k, d, i, m, w, r, s, b, j, n} = '0;
      a = 0;
      k = 1;
      if (op == 0) begin
         d = 1; w = 1;
         if (fn == 32 || fn == 33) a = 2;
         else if (fn == 34 || fn == 35) begin a = 2; n = 1; end
         else if (fn == 36) a = 0;
         else if (fn == 37) a = 1;
         else if (fn == 38) a = 4;
         else if (fn == 42) begin a = 3; n = 1; end
         else begin k = 0; d = 0; w = 0; end
      end else if (op == 8 || op == 9) begin i = 1; w = 1; a = 2; end
      else if (op == 10) begin i = 1; w = 1; a = 3; n = 1; end
      else if (op == 35) begin i = 1; r = 1; m = 1; w = 1; a = 2; end
      else if (op == 43) begin i = 1; s = 1; a = 2; end
      else if (op == 4)  begin b = 1; a = 2; n = 1; end
      else if (op == 2)  j = 1;
      else k = 0;
      return {k, d, i, m, w, r, s, b, j, 3'(a), n};
   endfunction

   function automatic string tag_of(input int op, input int fn);
      if (op == 0) return (model(op, fn)[12] ? "R1" : "R8");
      if (op == 8 || op == 9) return "R2 R10";
      if (op == 10) return "R3 R10";
      if (op == 35) return "R4 R10";
      if (op == 43) return "R5 R10";
      if (op == 4)  return "R6 R10";
      if (op == 2)  return "R7 R10";
      return "R8 R10";
   endfunction

   function automatic logic [12:0] observed();
      return {known, dst_rd, src_imm, wb_mem, reg_we, mem_rd, mem_wr,
              br_eq, jmp, alu_op, alu_neg};
   endfunction

   task automatic compare(input string tag, input int op, input int fn);
      logic [12:0] exp_v;
      logic [12:0] got_v;
      exp_v = model(op, fn);
      got_v = observed();
      checks++;
      if (got_v !== exp_v) begin
         errors++;
         $display("FAIL %s op=%02h fn=%02h actual=%013b expected=%013b",
                  tag, op, fn, got_v, exp_v);
      end
      checks++;
      if (spare !== '0) begin
         errors++;
         $display("FAIL R9 op=%02h fn=%02h actual=%h expected=0", op, fn, spare);
      end
      checks++;
      if (!reg_we && (dst_rd || wb_mem)) begin
         errors++;
         $display("FAIL R11 op=%02h fn=%02h actual dst=%0b wbm=%0b expected 0 0",
                  op, fn, dst_rd, wb_mem);
      end
   endtask

   task automatic apply(input string tag, input int op, input int fn);
      @(posedge clk);
      #1;
      opcode = 6'(op);
      funct  = 6'(fn);
      @(negedge clk);
      compare(tag, op, fn);
   endtask

   initial begin : watchdog
      while (!done) begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
         end
      end
   end

   initial begin : stim
      opcode = 6'h3F;
      funct  = 6'h3F;
      repeat (3) @(posedge clk);
      @(negedge clk);
      compare("R8 reset", 63, 63);
      rst_n = 1'b1;

      // Directed: each supported instruction and neighbouring codes
      apply("R1 add",  0, 32);  apply("R1 addu", 0, 33);
      apply("R1 sub",  0, 34);  apply("R1 subu", 0, 35);
      apply("R1 and",  0, 36);  apply("R1 or",   0, 37);
      apply("R1 xor",  0, 38);  apply("R1 slt",  0, 42);
      apply("R8 funct 0x27", 0, 39); apply("R8 funct 0x2B", 0, 43);
      apply("R8 funct 0x00", 0, 0);
      apply("R2 addi", 8, 0);   apply("R2 addiu", 9, 0);
      apply("R3 slti", 10, 0);
      apply("R4 lw", 35, 0);    apply("R5 sw", 43, 0);
      apply("R6 beq", 4, 0);    apply("R7 j", 2, 0);
      apply("R8 opcode 0x05", 5, 0); apply("R8 opcode 0x0B", 11, 0);
      apply("R10 addi fn xor", 8, 38); apply("R10 lw fn slt", 35, 42);
      apply("R10 j fn add", 2, 32);

      // Exhaustive sweep of every opcode/function pair
      for (int op = 0; op < 64; op++) begin
         for (int fn = 0; fn < 64; fn++) begin
            apply(tag_of(op, fn), op, fn);
         end
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule